// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Flags

This block is a first-in first-out buffer for 9-bit words. Its write side and read side each run on a clock of their own. The two clocks may be the same net or fully unrelated, and a write and a read may occur in the same cycle. The depth is a power of two set by `ADDR_W`. Enables are active low. A word is stored when the first write enable is low and the load/enable pin is high. A word is taken when both read enables are low. The read word sits in an output register, and that register is visible at `data_o` only while `oe_ni` is low.

Four active-low status flags report the buffer state: empty, full, almost-empty and almost-full. The two almost thresholds come from four byte-wide offset registers, which reach the block through the normal data pins.

- Pulling the load/enable pin low together with the first write enable loads the offset registers, one per write-clock edge.
- Pulling the load/enable pin low while both read enables are low reads the offset registers back through the output register, one per read-clock edge.

Pointers cross between the clock domains in Gray code. Full and almost-full are computed on the write side; empty and almost-empty on the read side.

Top module: `dcf_fifo`

## Requirements
- R1: While `wen1_ni`=0 and `wen2_ld_i`=1 and the buffer is not full, every rising `wclk_i` edge stores `data_i`. Words come out in the order they went in.
- R2: A word is read, and the read pointer advances, only on a rising `rclk_i` edge with `ren1_ni`=0, `ren2_ni`=0 and `wen2_ld_i`=1. With either read enable high, the output register keeps its value.
- R3: `full_no` is 0 exactly when 2^ADDR_W words are stored. A write attempted while full is dropped and the stored contents are unchanged.
- R4: `empty_no` is 0 exactly when no word is stored. A read attempted while empty is dropped and the output register holds its last value.
- R5: `afull_no` is 0 while the number of free locations is less than or equal to the full offset. The full offset is {byte 3, byte 2} of the offset registers.
- R6: `aempty_no` is 0 while the number of stored words is less than or equal to the empty offset. The empty offset is {byte 1, byte 0}.
- R7: With `wen1_ni`=0 and `wen2_ld_i`=0, each rising `wclk_i` edge copies `data_i[7:0]` into the next offset byte, in the order 0 (empty low), 1 (empty high), 2 (full low), 3 (full high). The order then wraps to byte 0. No FIFO word is stored, and `data_i[8]` is ignored.
- R8: With `wen2_ld_i`=0, `ren1_ni`=0 and `ren2_ni`=0, each rising `rclk_i` edge loads {1'b0, next offset byte} into the output register, in the same 0..3 wrapping order. This pointer is kept apart from the load pointer.
- R9: Reset (`rst_ni`=0) drives `empty_no`=0, `aempty_no`=0, `full_no`=1, `afull_no`=1 and clears the output register. It returns both offset sequence pointers to byte 0. It loads every offset with `DEF_OFS`, which is 2 by default.
- R10: While `oe_ni`=1, `data_o` reads 0 and `data_oe_o`=0. While `oe_ni`=0, `data_oe_o`=1 and `data_o` shows the output register.
- R11: Writes and reads running concurrently on unrelated clocks deliver every word exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen1_ni | input | 1 | Write enable, active low |
| wen2_ld_i | input | 1 | Write enable (high) / offset access select (low) |
| data_i | input | 9 | Write data; bits 7:0 also carry offset bytes |
| ren1_ni | input | 1 | Read enable 1, active low |
| ren2_ni | input | 1 | Read enable 2, active low |
| oe_ni | input | 1 | Output enable, active low |
| data_o | output | 9 | Output register, zero while disabled |
| data_oe_o | output | 1 | High while `data_o` is driven |
| empty_no | output | 1 | Empty, active low |
| full_no | output | 1 | Full, active low |
| aempty_no | output | 1 | Almost-empty, active low |
| afull_no | output | 1 | Almost-full, active low |

## Verification
The read-side properties decode `wen2_ld_i` on `rclk_i`, although that pin belongs to the write side. They therefore assume the pin is quasi-static with respect to the read clock. The bench changes it only while both read enables are high, and then lets several cycles of both clocks pass before any read or readback.

The offset bytes also cross into the read domain without a synchroniser. For that reason the bench loads offsets only while the FIFO traffic that depends on them is idle.

All other inputs change on the falling edge of their own clock, so no property ever sees them change at a sampling edge.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int unsigned DATA_W = 9;
  localparam int unsigned OFS_W  = 16;
  localparam int unsigned NOFS   = 4;

  // Offset byte index; order is the access sequence
  typedef enum logic [1:0] {
    OFS_E_LO = 2'd0,
    OFS_E_HI = 2'd1,
    OFS_F_LO = 2'd2,
    OFS_F_HI = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int unsigned        ADDR_W  = 4,
  parameter logic [OFS_W-1:0]   DEF_OFS = 16'd2
) (
  input  logic                    wclk_i,
  input  logic                    rst_ni,
  input  logic                    wen1_ni,
  input  logic                    wen2_ld_i,
  input  logic [7:0]              byte_i,
  input  logic [ADDR_W:0]         rgray_i,
  output logic [ADDR_W:0]         wptr_o,
  output logic [ADDR_W:0]         wgray_o,
  output logic                    we_o,
  output logic                    full_no,
  output logic                    afull_no,
  output logic [NOFS-1:0][7:0]    ofs_o
);
  localparam int unsigned PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_C = PW'(1) << ADDR_W;

  logic [PW-1:0] wptr_q, wgray_q, rbin, used, free_cnt, wptr_nx;
  logic [NOFS-1:0][7:0] ofs_q;
  ofs_sel_e ld_sel_q;
  logic wr_req, ld_req, full;

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign rbin[i] = ^rgray_i[PW-1:i];
  end

  assign wr_req   = !wen1_ni && wen2_ld_i;
  assign ld_req   = !wen1_ni && !wen2_ld_i;
  assign used     = wptr_q - rbin;
  assign free_cnt = DEPTH_C - used;
  assign full     = (used == DEPTH_C);
  assign we_o     = wr_req && !full;
  assign wptr_nx  = wptr_q + PW'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wptr_q  <= wptr_nx;
      wgray_q <= wptr_nx ^ (wptr_nx >> 1);
    end
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NOFS; i++) ofs_q[i] <= (i[0]) ? DEF_OFS[15:8] : DEF_OFS[7:0];
      ld_sel_q <= OFS_E_LO;
    end else if (ld_req) begin
      ofs_q[ld_sel_q] <= byte_i;
      ld_sel_q        <= ofs_sel_e'(ld_sel_q + 2'd1);
    end
  end

  assign wptr_o   = wptr_q;
  assign wgray_o  = wgray_q;
  assign ofs_o    = ofs_q;
  assign full_no  = !full;
  assign afull_no = !({{(OFS_W-PW){1'b0}}, free_cnt} <= {ofs_q[OFS_F_HI], ofs_q[OFS_F_LO]});
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                  rclk_i,
  input  logic                  rst_ni,
  input  logic                  ren1_ni,
  input  logic                  ren2_ni,
  input  logic                  ld_mode_i,
  input  logic [ADDR_W:0]       wgray_i,
  input  logic [NOFS-1:0][7:0]  ofs_i,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  output logic [ADDR_W:0]       rptr_o,
  output logic [ADDR_W:0]       rgray_o,
  output logic [DATA_W-1:0]     q_o,
  output logic                  empty_no,
  output logic                  aempty_no
);
  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0] rptr_q, rgray_q, wbin, used, rptr_nx;
  logic [DATA_W-1:0] q_q;
  ofs_sel_e rb_sel_q;
  logic rd_cmd, rd_req, rb_req, empty, re;

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign wbin[i] = ^wgray_i[PW-1:i];
  end

  assign rd_cmd  = !ren1_ni && !ren2_ni;
  assign rd_req  = rd_cmd && !ld_mode_i;
  assign rb_req  = rd_cmd && ld_mode_i;
  assign used    = wbin - rptr_q;
  assign empty   = (used == '0);
  assign re      = rd_req && !empty;
  assign rptr_nx = rptr_q + PW'(1);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q   <= '0;
      rgray_q  <= '0;
      q_q      <= '0;
      rb_sel_q <= OFS_E_LO;
    end else if (re) begin
      rptr_q  <= rptr_nx;
      rgray_q <= rptr_nx ^ (rptr_nx >> 1);
      q_q     <= mem_rdata_i;
    end else if (rb_req) begin
      q_q      <= {1'b0, ofs_i[rb_sel_q]};
      rb_sel_q <= ofs_sel_e'(rb_sel_q + 2'd1);
    end
  end

  assign rptr_o    = rptr_q;
  assign rgray_o   = rgray_q;
  assign q_o       = q_q;
  assign empty_no  = !empty;
  assign aempty_no = !({{(OFS_W-PW){1'b0}}, used} <= {ofs_i[OFS_E_HI], ofs_i[OFS_E_LO]});
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int unsigned      ADDR_W  = 4,
  parameter logic [OFS_W-1:0] DEF_OFS = 16'd2
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wen1_ni,
  input  logic              wen2_ld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ren1_ni,
  input  logic              ren2_ni,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              empty_no,
  output logic              full_no,
  output logic              aempty_no,
  output logic              afull_no
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ADDR_W:0] wptr, wgray, rptr, rgray, wgray_rs, rgray_ws;
  logic [NOFS-1:0][7:0] ofs;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] q;
  logic we;

  dcf_wr_ctrl #(.ADDR_W(ADDR_W), .DEF_OFS(DEF_OFS)) u_wr (
    .wclk_i, .rst_ni, .wen1_ni, .wen2_ld_i,
    .byte_i  (data_i[7:0]),
    .rgray_i (rgray_ws),
    .wptr_o  (wptr),
    .wgray_o (wgray),
    .we_o    (we),
    .full_no, .afull_no,
    .ofs_o   (ofs)
  );

  dcf_sync #(.W(ADDR_W+1)) u_r2w (.clk_i(wclk_i), .rst_ni, .d_i(rgray), .q_o(rgray_ws));
  dcf_sync #(.W(ADDR_W+1)) u_w2r (.clk_i(rclk_i), .rst_ni, .d_i(wgray), .q_o(wgray_rs));

  always_ff @(posedge wclk_i) begin
    if (we) mem[wptr[ADDR_W-1:0]] <= data_i;
  end

  dcf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .rclk_i, .rst_ni, .ren1_ni, .ren2_ni,
    .ld_mode_i   (!wen2_ld_i),
    .wgray_i     (wgray_rs),
    .ofs_i       (ofs),
    .mem_rdata_i (mem[rptr[ADDR_W-1:0]]),
    .rptr_o      (rptr),
    .rgray_o     (rgray),
    .q_o         (q),
    .empty_no, .aempty_no
  );

  assign data_oe_o = !oe_ni;
  assign data_o    = oe_ni ? '0 : q;
endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
module dcf_fifo_chk #(
  parameter int unsigned AW = 4
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wen1_ni,
  input logic          wen2_ld_i,
  input logic          ren1_ni,
  input logic          ren2_ni,
  input logic          oe_ni,
  input logic [8:0]    data_o,
  input logic          data_oe_o,
  input logic          empty_no,
  input logic          full_no,
  input logic          aempty_no,
  input logic          afull_no,
  input logic [AW:0]   wptr,
  input logic [AW:0]   rptr,
  input logic [8:0]    q
);
  a_r1_write_advances: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wen1_ni && wen2_ld_i && full_no) |=> (wptr == (AW+1)'($past(wptr) + 1'b1)));

  a_r3_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wen1_ni && wen2_ld_i && !full_no) |=> $stable(wptr));

  a_r4_no_underflow: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!ren1_ni && !ren2_ni && wen2_ld_i && !empty_no) |=> ($stable(rptr) && $stable(q)));

  a_r2_hold_idle: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ren1_ni || ren2_ni) |=> ($stable(rptr) && $stable(q)));

  a_r5_full_in_afull: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !afull_no);

  a_r6_empty_in_aempty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no);

  a_r10_oe_blank: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    oe_ni |-> (data_o == 9'd0 && !data_oe_o));
endmodule

bind dcf_fifo dcf_fifo_chk #(.AW(ADDR_W)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
  .wen1_ni(wen1_ni), .wen2_ld_i(wen2_ld_i), .ren1_ni(ren1_ni), .ren2_ni(ren2_ni),
  .oe_ni(oe_ni), .data_o(data_o), .data_oe_o(data_oe_o),
  .empty_no(empty_no), .full_no(full_no), .aempty_no(aempty_no), .afull_no(afull_no),
  .wptr(wptr), .rptr(rptr), .q(q)
);

// File: tb/sim_dcf_fifo.sv
`timescale 1ns/1ps
module sim_dcf_fifo;
  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wen1 = 1, wen2 = 1, ren1 = 1, ren2 = 1, oe_n = 0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic dout_oe, empty_n, full_n, aempty_n, afull_n;

  int checks = 0, errors = 0;
  logic [7:0] ofs_m [4];
  int rb_idx = 0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dcf_fifo u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wen1_ni(wen1), .wen2_ld_i(wen2), .data_i(din),
    .ren1_ni(ren1), .ren2_ni(ren2), .oe_ni(oe_n),
    .data_o(dout), .data_oe_o(dout_oe),
    .empty_no(empty_n), .full_no(full_n), .aempty_no(aempty_n), .afull_no(afull_n)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wdrive(logic w1, logic w2, logic [8:0] d);
    @(negedge wclk); wen1 = w1; wen2 = w2; din = d;
  endtask

  task automatic widle();
    @(negedge wclk); wen1 = 1; wen2 = 1;
  endtask

  task automatic settle();
    repeat (5) @(negedge wclk);
    repeat (5) @(negedge rclk);
  endtask

  task automatic pop(output logic [8:0] d);
    @(negedge rclk); ren1 = 0; ren2 = 0;
    @(negedge rclk); ren1 = 1; ren2 = 1; d = dout;
  endtask

  task automatic readback(int n, string req);
    logic [8:0] d;
    wdrive(1, 0, '0);
    settle();
    for (int i = 0; i < n; i++) begin
      pop(d);
      check(req, {7'd0, d}, {8'd0, ofs_m[rb_idx]});
      rb_idx = (rb_idx + 1) % 4;
    end
    widle();
    settle();
  endtask

  task automatic load4(logic [8:0] b0, logic [8:0] b1, logic [8:0] b2, logic [8:0] b3);
    wdrive(0, 0, b0); wdrive(0, 0, b1); wdrive(0, 0, b2); wdrive(0, 0, b3);
    widle();
    ofs_m[0] = b0[7:0]; ofs_m[1] = b1[7:0]; ofs_m[2] = b2[7:0]; ofs_m[3] = b3[7:0];
    settle();
  endtask

  task automatic t_reset();
    check("R9 empty", {15'd0, empty_n}, 16'd0);
    check("R9 aempty", {15'd0, aempty_n}, 16'd0);
    check("R9 full", {15'd0, full_n}, 16'd1);
    check("R9 afull", {15'd0, afull_n}, 16'd1);
    check("R9 q clear", {7'd0, dout}, 16'd0);
    check("R10 oe low", {15'd0, dout_oe}, 16'd1);
  endtask

  task automatic t_offsets();
    for (int i = 0; i < 4; i++) ofs_m[i] = (i % 2 == 0) ? 8'd2 : 8'd0;
    readback(5, "R9/R8 default readback wrap");
    load4(9'h1AA, 9'h011, 9'h055, 9'h022);
    check("R7 no word stored", {15'd0, empty_n}, 16'd0);
    readback(4, "R7/R8 loaded bytes");
    load4(9'h003, 9'h000, 9'h004, 9'h000);
    readback(4, "R7 load wrap");
  endtask

  task automatic t_fill();
    for (int i = 0; i < 11; i++) wdrive(0, 1, 9'(9'h100 + i));
    widle();
    check("R5 free5 afull high", {15'd0, afull_n}, 16'd1);
    check("R3 not full", {15'd0, full_n}, 16'd1);
    wdrive(0, 1, 9'h10B); widle();
    check("R5 free4 afull low", {15'd0, afull_n}, 16'd0);
    for (int i = 12; i < 16; i++) wdrive(0, 1, 9'(9'h100 + i));
    widle();
    check("R3 full", {15'd0, full_n}, 16'd0);
    wdrive(0, 1, 9'h1FF); widle();
    check("R3 write while full", {15'd0, full_n}, 16'd0);
    settle();
  endtask

  task automatic t_drain();
    logic [8:0] d, prev;
    prev = dout;
    check("R4 not empty", {15'd0, empty_n}, 16'd1);
    @(negedge rclk); ren1 = 0; ren2 = 1;
    @(negedge rclk); ren1 = 1;
    check("R2 single enable no read", {7'd0, dout}, {7'd0, prev});
    for (int i = 0; i < 16; i++) begin
      pop(d);
      check("R1 order", {7'd0, d}, 16'(9'h100 + i));
      if (i == 11) check("R6 count4 aempty high", {15'd0, aempty_n}, 16'd1);
      if (i == 12) check("R6 count3 aempty low", {15'd0, aempty_n}, 16'd0);
    end
    check("R4 empty", {15'd0, empty_n}, 16'd0);
    pop(d);
    check("R4 read while empty holds", {7'd0, d}, 16'h010F);
    @(negedge rclk); oe_n = 1;
    @(negedge rclk);
    check("R10 oe high data", {7'd0, dout}, 16'd0);
    check("R10 oe high flag", {15'd0, dout_oe}, 16'd0);
    oe_n = 0;
    @(negedge rclk);
    check("R10 oe low data", {7'd0, dout}, 16'h010F);
  endtask

  task automatic t_concurrent();
    fork
      begin
        int n = 0;
        while (n < 20) begin
          @(negedge wclk);
          if (full_n) begin wen1 = 0; wen2 = 1; din = 9'(9'h040 + n); n++; end
          else wen1 = 1;
        end
        @(negedge wclk); wen1 = 1;
      end
      begin
        int got = 0;
        bit pend = 0;
        while (got < 20) begin
          @(negedge rclk);
          if (pend) begin
            check("R11 concurrent order", {7'd0, dout}, 16'(9'h040 + got));
            got++;
          end
          if (got < 20 && empty_n) begin ren1 = 0; ren2 = 0; pend = 1; end
          else begin ren1 = 1; ren2 = 1; pend = 0; end
        end
        ren1 = 1; ren2 = 1;
      end
    join
    settle();
    check("R11 empty after", {15'd0, empty_n}, 16'd0);
  endtask

  initial begin
    fork
      begin
        #35 rst_n = 1;
        settle();
        t_reset();
        t_offsets();
        t_fill();
        t_drain();
        t_concurrent();
      end
      begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule